// File: doc/BRIEF.md
# Hill-Climbing Dither Direction Controller

This block chooses, once per dither period, whether the operating point of a power converter should move up or down. It runs from the same clock that synchronizes the converter's switching. A free-running binary divider splits that clock into a base period of 2^DIV_W cycles. Inside each period the divider produces two non-overlapping, active-low strobes that drive the external sample-and-hold switches. Because the strobes come from the switching clock, every power sample is taken at the same phase of the switching cycle.

On the last count of each period the block reads one comparator bit, `pwr_rise`, which is high when the new power sample is larger than the previous one. The size of the change is never used. A stored direction bit is kept when power rose and reversed when power fell. The new direction is registered as the step command, and a one-cycle step-enable pulse goes with it. Near the peak this rule makes the operating point oscillate around the maximum, taking at least two steps each way.

A global-run input hands control to a separate sweep. While global-run is high, the step outputs are forced low and the direction memory is frozen.

Top module: `dither_dir_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `step_up`=0, `step_en`=0, `samp_a_n`=1, `samp_b_n`=1 and `base_clk`=0, and the stored direction becomes up.
- R2: After reset is released, the divider count reads k mod 2^DIV_W once k edges have passed. `base_clk` is high exactly when the count is in the upper half of that range, which is counts 16 to 31 for the default DIV_W=5.
- R3: `samp_a_n` is low exactly at counts 24 to 27 and `samp_b_n` is low exactly at counts 28 and 29 (default DIV_W). The two strobes are never low in the same cycle.
- R4: `pwr_rise` is sampled only at the edge that ends a period, which is the edge where the count wraps from 31 to 0. Its value in every other cycle has no effect on `step_up` or on the direction.
- R5: At the period-end edge, with `global_run` low, the stored direction is kept if `pwr_rise`=1 and inverted if `pwr_rise`=0. `step_up` takes the new direction in the same edge, with 1 meaning up and 0 meaning down.
- R6: `step_en` is high for exactly the one cycle that follows each period-end edge taken with `global_run` low. It is low in every other cycle.
- R7: While `global_run` is high, `step_up` and `step_en` are low from the next edge on, and the stored direction does not change. After `global_run` falls, `step_up` stays low until the next period-end edge.
- R8: `step_up` stays low during the first full period after reset, even though the stored direction is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter switching clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_rise | input | 1 | Comparator bit: 1 when the newest power sample exceeds the previous one |
| global_run | input | 1 | Global sweep active; forces the step outputs low and freezes the direction |
| samp_a_n | output | 1 | First sample strobe, active low |
| samp_b_n | output | 1 | Second sample strobe, active low |
| base_clk | output | 1 | Base dither period signal (divider MSB) |
| step_up | output | 1 | Step direction command: 1 = up, 0 = down |
| step_en | output | 1 | One-cycle pulse asking for a step |

## Verification
Every output comes from a register, so the expected values are counted in edges from the release of reset. After k edges the count is k mod 32, and the strobes and `base_clk` follow that count in the same cycle. `step_up` and `step_en` change only at edge 32, 64 and so on, and at that edge they reflect the `pwr_rise` value driven just before it. A `global_run` change shows on the outputs one edge after it is applied. The bench drives all inputs on falling edges and samples the outputs after each rising edge. It drives the inverted `pwr_rise` in the other 31 cycles of each period and checks the decision only after the period-end edge.

// File: rtl/dither_pkg.sv
package dither_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/dither_divider.sv
// Free-running divider: period count, sample strobes, period-end tick.
module dither_divider #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  output logic [DIV_W-1:0] cnt,
  output logic             samp_a_n,
  output logic             samp_b_n,
  output logic             period_end
);
  localparam logic [DIV_W-1:0] CNT_LAST = {DIV_W{1'b1}};

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic             a_nxt_n;
  logic             b_nxt_n;

  // Strobes are decoded from the next count and registered, so each one lines up with the count it belongs to.
  always_comb begin
    cnt_nxt = cnt_q + 1'b1;
    a_nxt_n = ~(cnt_nxt[DIV_W-1] & cnt_nxt[DIV_W-2] & ~cnt_nxt[DIV_W-3]);
    b_nxt_n = ~(cnt_nxt[DIV_W-1] & cnt_nxt[DIV_W-2] & cnt_nxt[DIV_W-3]
                & ~cnt_nxt[DIV_W-4]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      samp_a_n <= 1'b1;
      samp_b_n <= 1'b1;
    end else begin
      cnt_q    <= cnt_nxt;
      samp_a_n <= a_nxt_n;
      samp_b_n <= b_nxt_n;
    end
  end

  assign cnt        = cnt_q;
  assign period_end = (cnt_q == CNT_LAST);
endmodule

// File: rtl/dither_dir_mem.sv
// Direction memory: keep on rise, reverse on fall.
module dither_dir_mem
  import dither_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic period_end,
  input  logic hold,
  input  logic pwr_rise,
  output dir_e dir_q,
  output dir_e dir_nxt
);
  always_comb begin
    dir_nxt = pwr_rise ? dir_q : dir_e'(~dir_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_UP;
    end else if (period_end && !hold) begin
      dir_q <= dir_nxt;
    end
  end
endmodule

// File: rtl/dither_step_reg.sv
// Registered step command and step-enable with global override.
module dither_step_reg
  import dither_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic period_end,
  input  logic hold,
  input  dir_e dir_nxt,
  output logic step_up,
  output logic step_en
);
  always_ff @(posedge clk) begin
    if (rst || hold) begin
      step_up <= 1'b0;
      step_en <= 1'b0;
    end else begin
      step_en <= period_end;
      if (period_end) begin
        step_up <= (dir_nxt == DIR_UP);
      end
    end
  end
endmodule

// File: rtl/dither_dir_ctrl.sv
module dither_dir_ctrl
  import dither_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_rise,
  input  logic global_run,
  output logic samp_a_n,
  output logic samp_b_n,
  output logic base_clk,
  output logic step_up,
  output logic step_en
);
  logic [DIV_W-1:0] cnt_w;
  logic             period_end_w;
  dir_e             dir_w;
  dir_e             dir_nxt_w;

  dither_divider #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .cnt        (cnt_w),
    .samp_a_n   (samp_a_n),
    .samp_b_n   (samp_b_n),
    .period_end (period_end_w)
  );

  dither_dir_mem u_mem (
    .clk        (clk),
    .rst        (rst),
    .period_end (period_end_w),
    .hold       (global_run),
    .pwr_rise   (pwr_rise),
    .dir_q      (dir_w),
    .dir_nxt    (dir_nxt_w)
  );

  dither_step_reg u_step (
    .clk        (clk),
    .rst        (rst),
    .period_end (period_end_w),
    .hold       (global_run),
    .dir_nxt    (dir_nxt_w),
    .step_up    (step_up),
    .step_en    (step_en)
  );

  assign base_clk = cnt_w[DIV_W-1];
endmodule

// File: rtl/dither_dir_chk.sv
module dither_dir_chk #(
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_rise,
  input logic             global_run,
  input logic             samp_a_n,
  input logic             samp_b_n,
  input logic             step_up,
  input logic             step_en,
  input logic [DIV_W-1:0] cnt,
  input logic             dir
);
  localparam logic [DIV_W-1:0] CNT_LAST = {DIV_W{1'b1}};

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!samp_a_n && !samp_b_n));

  a_r6_en_single_cycle: assert property (@(posedge clk) disable iff (rst)
    step_en |=> !step_en);

  a_r6_en_after_period_end: assert property (@(posedge clk) disable iff (rst)
    step_en |-> ($past(cnt) == CNT_LAST));

  a_r7_override_low: assert property (@(posedge clk) disable iff (rst)
    global_run |=> (!step_up && !step_en));

  a_r5_direction_rule: assert property (@(posedge clk) disable iff (rst)
    step_en |-> (step_up == ($past(pwr_rise) ? $past(dir) : !$past(dir))));

  a_r4_dir_only_at_end: assert property (@(posedge clk) disable iff (rst)
    (cnt != CNT_LAST) |=> $stable(dir));
endmodule

bind dither_dir_ctrl dither_dir_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_rise   (pwr_rise),
  .global_run (global_run),
  .samp_a_n   (samp_a_n),
  .samp_b_n   (samp_b_n),
  .step_up    (step_up),
  .step_en    (step_en),
  .cnt        (cnt_w),
  .dir        (dir_w)
);

// File: tb/dither_dir_ctrl_test.sv
module dither_dir_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_rise = 1'b0;
  logic global_run = 1'b0;
  logic samp_a_n, samp_b_n, base_clk, step_up, step_en;
  int   errors = 0;
  int   checks = 0;
  logic done = 1'b0;

  dither_dir_ctrl #(.DIV_W(5)) uut (
    .clk        (clk),
    .rst        (rst),
    .pwr_rise   (pwr_rise),
    .global_run (global_run),
    .samp_a_n   (samp_a_n),
    .samp_b_n   (samp_b_n),
    .base_clk   (base_clk),
    .step_up    (step_up),
    .step_en    (step_en)
  );

  always #10 clk = ~clk;

  // {pwr_rise, global_run, expected step_up, expected step_en}; direction starts up
  localparam logic [3:0] VEC [0:9] = '{
    4'b1011, 4'b0001, 4'b0011, 4'b1011, 4'b1011,
    4'b0001, 4'b1001, 4'b0100, 4'b1100, 4'b0011
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One full period; pwr_rise is inverted except just before the period-end edge
  task automatic run_period(input logic rise, input logic grun,
                            input logic exp_up, input logic exp_en,
                            input logic first);
    int bad_strobe = 0;
    int bad_base = 0;
    int bad_en = 0;
    int bad_up = 0;
    global_run = grun;
    for (int i = 1; i <= 32; i++) begin
      pwr_rise = (i == 32) ? rise : ~rise;
      tick();
      if (i < 32) begin
        int c = i % 32;
        if (samp_a_n != !(c >= 24 && c <= 27)) bad_strobe++;
        if (samp_b_n != !(c == 28 || c == 29)) bad_strobe++;
        if (base_clk != (c >= 16)) bad_base++;
        if (step_en) bad_en++;
        if ((first || grun) && step_up) bad_up++;
      end
    end
    check("R3 strobe windows", bad_strobe, 0);
    check("R2 base period", bad_base, 0);
    check("R6 no enable mid-period", bad_en, 0);
    check(first ? "R8 step low first period" : "R7 step low under override", bad_up, 0);
    check("R5/R4 step_up after decision", step_up, exp_up);
    check("R6/R7 step_en after decision", step_en, exp_en);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick(); tick();
    // R1 reset state
    check("R1 step_up", step_up, 0);
    check("R1 step_en", step_en, 0);
    check("R1 samp_a_n", samp_a_n, 1);
    check("R1 samp_b_n", samp_b_n, 1);
    check("R1 base_clk", base_clk, 0);
    rst = 1'b0;

    for (int v = 0; v < 10; v++) begin
      run_period(VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], v == 0);
    end
    tick();
    check("R6 enable drops after one cycle", step_en, 0);

    // R1: reset in mid-period restores direction up and the divider phase
    for (int i = 0; i < 4; i++) tick();
    rst = 1'b1;
    tick();
    check("R1 mid reset step_up", step_up, 0);
    check("R1 mid reset base_clk", base_clk, 0);
    rst = 1'b0;
    run_period(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);   // R5: up reversed to down
    run_period(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);   // R5: down reversed to up

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule